// File: doc/BRIEF.md
# Dual-Capture Interval Timer

This block is a free-running 32-bit up-counter with a small register port and an input-capture path. An external pin, once it has been selected as the capture input, passes through a two-flop synchroniser and an edge detector. The transitions picked by an edge-select field copy the running count into capture registers. Software takes the difference of the two captures, modulo 2^32, to measure a signal's interval.

With only rising edges selected, the two captures lie one period apart. With both edges selected, and the pin low at arming, the difference is the high time. The usual sequence is as follows. Software stops the timer, clears the count and writes the control word with start set. It then waits for both capture flags and subtracts. Writing the control word with the lower sixteen bits cleared except start leaves the counter running with capture off.

Register map (3-bit word address, combinational read):

| Address | Register |
|---|---|
| 0 | control |
| 1 | count |
| 2 | reload value |
| 3 | first capture |
| 4 | second capture |
| 5 | status |

Control bits:

| Bit | Function |
|---|---|
| 0 | run |
| 1 | reload on overflow |
| 9:8 | edge select |
| 13 | paired capture |
| 14 | pin is capture input |

Status bits:

| Bit | Meaning |
|---|---|
| 0 | first capture loaded |
| 1 | second capture loaded |

Top module: `capTimer`

## Requirements
- R1: After reset, every register reads 0.
- R2: While control bit 0 is 1 the count rises by one per clock. While it is 0 the count holds.
- R3: A write to address 1 loads the count on that clock edge and takes priority over incrementing. Counting continues from the written value.
- R4: When the count is all ones and the timer is running, the next value is 0 if control bit 1 is 0, and the reload register (address 2) if control bit 1 is 1.
- R5: Control bits 9:8 select the events: 00 none, 01 rising, 10 falling, 11 both. No capture occurs while bits 9:8 are 00, while bit 14 is 0, or while bit 0 is 0.
- R6: With control bit 13 set, the first event loads address 3 and the second loads address 4. Later events are ignored until the control register is written again, which rearms the sequence at address 3.
- R7: With control bit 13 clear, every event loads address 3 and address 4 is left unchanged.
- R8: In paired mode, address 4 minus address 3 (mod 2^32) equals the number of clocks between the two events, also across a counter wrap. Rising-only or falling-only events give the period. Both-edge events, with the pin low at arming, give the high time.
- R9: Take the count read in the clock cycle in which the pin changes. The captured value is that count plus 2 (two synchroniser stages).
- R10: Status bit 0 sets when address 3 is loaded and bit 1 sets when address 4 is loaded. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R11: Writing the control word with all lower sixteen bits 0 except bit 0 keeps the counter running and disables capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous active-low reset |
| regWe | input | 1 | write strobe |
| regAddr | input | 3 | word address |
| regWdata | input | 32 | write data |
| regRdata | output | 32 | read data for regAddr (combinational) |
| capPin | input | 1 | asynchronous capture input |

## Verification
A wrong capture slot pointer would show at the ports within a single event. Either the second capture register changes when it should not, or a status bit is missing once the edge has cleared the synchroniser, three clocks after the pin moves. A counter stepping wrongly, or mishandling the overflow point, corrupts the count on the very next read. An extra or missing synchroniser stage shifts the absolute captured value by one count even when differences stay correct. For that reason the latency is checked against a count read in the cycle the pin changes.

// File: rtl/capTimerPkg.sv
package capTimerPkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOAD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAP1  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAP2  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd5;

  localparam int B_RUN    = 0;
  localparam int B_RELOAD = 1;
  localparam int B_SEL_LO = 8;
  localparam int B_PAIR   = 13;
  localparam int B_PIN    = 14;

  typedef struct packed {
    logic       pinCap;
    logic       pairMode;
    logic [1:0] edgeSel;
    logic       autoReload;
    logic       run;
  } ctrlT;

  typedef struct packed {
    logic cntWr;
    logic loadWr;
    logic cap1Ld;
    logic cap2Ld;
  } strobeT;

  typedef enum logic [1:0] {SLOT_FIRST, SLOT_SECOND, SLOT_DONE} slotT;
endpackage

// File: rtl/capTimerEdge.sv
module capTimerEdge #(
  parameter int SyncStages = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic rise,
  output logic fall
);
  logic [SyncStages-1:0] syncQ;
  logic prevQ;

  generate
    for (genvar i = 0; i < SyncStages; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= pinIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[i] <= 1'b0;
          else       syncQ[i] <= syncQ[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[SyncStages-1];
  end

  assign rise = syncQ[SyncStages-1] & ~prevQ;
  assign fall = ~syncQ[SyncStages-1] & prevQ;
endmodule

// File: rtl/capTimerCtrl.sv
module capTimerCtrl
  import capTimerPkg::*;
#(
  parameter int DataW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DataW-1:0]  regWdata,
  input  logic              rise,
  input  logic              fall,
  output ctrlT              ctrlQ,
  output logic [1:0]        statusQ,
  output strobeT            stb
);
  slotT slotQ;
  logic ctrlWr, statWr, evt;

  assign ctrlWr = regWe && (regAddr == A_CTRL);
  assign statWr = regWe && (regAddr == A_STAT);

  assign evt = ctrlQ.run && ctrlQ.pinCap &&
               ((ctrlQ.edgeSel[0] && rise) || (ctrlQ.edgeSel[1] && fall));

  always_comb begin
    stb        = '0;
    stb.cntWr  = regWe && (regAddr == A_COUNT);
    stb.loadWr = regWe && (regAddr == A_LOAD);
    stb.cap1Ld = evt && (slotQ == SLOT_FIRST);
    stb.cap2Ld = evt && ctrlQ.pairMode && (slotQ == SLOT_SECOND);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (ctrlWr) begin
      ctrlQ.run        <= regWdata[B_RUN];
      ctrlQ.autoReload <= regWdata[B_RELOAD];
      ctrlQ.edgeSel    <= regWdata[B_SEL_LO+1:B_SEL_LO];
      ctrlQ.pairMode   <= regWdata[B_PAIR];
      ctrlQ.pinCap     <= regWdata[B_PIN];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotQ <= SLOT_FIRST;
    end else if (ctrlWr) begin
      slotQ <= SLOT_FIRST;
    end else if (stb.cap2Ld) begin
      slotQ <= SLOT_DONE;
    end else if (stb.cap1Ld && ctrlQ.pairMode) begin
      slotQ <= SLOT_SECOND;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
    end else begin
      statusQ[0] <= stb.cap1Ld | (statusQ[0] & ~(statWr & regWdata[0]));
      statusQ[1] <= stb.cap2Ld | (statusQ[1] & ~(statWr & regWdata[1]));
    end
  end
endmodule

// File: rtl/capTimerDp.sv
module capTimerDp
  import capTimerPkg::*;
#(
  parameter int CntW = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlT            ctrlQ,
  input  strobeT          stb,
  input  logic [CntW-1:0] wdata,
  output logic [CntW-1:0] countQ,
  output logic [CntW-1:0] loadQ,
  output logic [CntW-1:0] cap1Q,
  output logic [CntW-1:0] cap2Q
);
  localparam logic [CntW-1:0] CNT_MAX = '1;
  localparam logic [CntW-1:0] CNT_ONE = CntW'(1);

  logic [CntW-1:0] countNext;

  always_comb begin
    countNext = countQ;
    if (stb.cntWr)                 countNext = wdata;
    else if (ctrlQ.run) begin
      if (countQ == CNT_MAX)       countNext = ctrlQ.autoReload ? loadQ : '0;
      else                         countNext = countQ + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      loadQ  <= '0;
      cap1Q  <= '0;
      cap2Q  <= '0;
    end else begin
      countQ <= countNext;
      if (stb.loadWr) loadQ <= wdata;
      if (stb.cap1Ld) cap1Q <= countQ;
      if (stb.cap2Ld) cap2Q <= countQ;
    end
  end
endmodule

// File: rtl/capTimer.sv
module capTimer
  import capTimerPkg::*;
#(
  parameter int CntW       = 32,
  parameter int SyncStages = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CntW-1:0]   regWdata,
  output logic [CntW-1:0]   regRdata,
  input  logic              capPin
);
  ctrlT            ctrlQ;
  strobeT          stb;
  logic [1:0]      statusQ;
  logic            rise, fall;
  logic [CntW-1:0] countQ, loadQ, cap1Q, cap2Q;
  logic [CntW-1:0] ctrlRd;

  capTimerEdge #(.SyncStages(SyncStages)) u_edge (
    .clk(clk), .rstN(rstN), .pinIn(capPin), .rise(rise), .fall(fall)
  );

  capTimerCtrl #(.DataW(CntW)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .rise(rise), .fall(fall),
    .ctrlQ(ctrlQ), .statusQ(statusQ), .stb(stb)
  );

  capTimerDp #(.CntW(CntW)) u_dp (
    .clk(clk), .rstN(rstN), .ctrlQ(ctrlQ), .stb(stb), .wdata(regWdata),
    .countQ(countQ), .loadQ(loadQ), .cap1Q(cap1Q), .cap2Q(cap2Q)
  );

  always_comb begin
    ctrlRd = '0;
    ctrlRd[B_RUN]                 = ctrlQ.run;
    ctrlRd[B_RELOAD]              = ctrlQ.autoReload;
    ctrlRd[B_SEL_LO+1:B_SEL_LO]   = ctrlQ.edgeSel;
    ctrlRd[B_PAIR]                = ctrlQ.pairMode;
    ctrlRd[B_PIN]                 = ctrlQ.pinCap;
  end

  always_comb begin
    case (regAddr)
      A_CTRL:  regRdata = ctrlRd;
      A_COUNT: regRdata = countQ;
      A_LOAD:  regRdata = loadQ;
      A_CAP1:  regRdata = cap1Q;
      A_CAP2:  regRdata = cap2Q;
      A_STAT:  regRdata = {{(CntW-2){1'b0}}, statusQ};
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/capTimerChk.sv
module capTimerChk #(
  parameter int CntW = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            run,
  input logic            autoReload,
  input logic            cntWr,
  input logic [CntW-1:0] count,
  input logic            cap1Ld,
  input logic            cap2Ld,
  input logic            pinCap,
  input logic [1:0]      status
);
  localparam logic [CntW-1:0] CNT_MAX = '1;

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (run && !cntWr && count != CNT_MAX) |=> (count == $past(count) + 1'b1));

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !cntWr) |=> $stable(count));

  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (run && !cntWr && !autoReload && count == CNT_MAX) |=> (count == '0));

  p_one_slot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cap1Ld, cap2Ld}));

  p_no_cap_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!run || !pinCap) |-> !(cap1Ld || cap2Ld));

  p_status_first_r10: assert property (@(posedge clk) disable iff (!rstN)
    cap1Ld |=> status[0]);

  p_status_second_r10: assert property (@(posedge clk) disable iff (!rstN)
    cap2Ld |=> status[1]);
endmodule

bind capTimer capTimerChk #(.CntW(CntW)) u_chk (
  .clk(clk), .rstN(rstN), .run(ctrlQ.run), .autoReload(ctrlQ.autoReload),
  .cntWr(stb.cntWr), .count(countQ), .cap1Ld(stb.cap1Ld),
  .cap2Ld(stb.cap2Ld), .pinCap(ctrlQ.pinCap), .status(statusQ)
);

// File: tb/capTimer_tb.sv
module capTimer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        capPin = 1'b0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  capTimer u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .capPin(capPin)
  );

  localparam logic [31:0] RUN  = 32'h1;
  localparam logic [31:0] ARL  = 32'h2;
  localparam logic [31:0] PAIR = 32'h2000;
  localparam logic [31:0] PIN  = 32'h4000;

  // {sel[25:24], high[23:16], low[15:8], expected diff[7:0]}
  localparam logic [31:0] VEC [5] = '{
    {6'd0, 2'b01, 8'd6,  8'd9, 8'd15},
    {6'd0, 2'b10, 8'd4,  8'd7, 8'd11},
    {6'd0, 2'b11, 8'd5,  8'd8, 8'd5},
    {6'd0, 2'b11, 8'd12, 8'd3, 8'd12},
    {6'd0, 2'b01, 8'd3,  8'd3, 8'd6}
  };

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdata;
  endtask

  task automatic pulse(input int h, input int l);
    capPin = 1'b1; step(h);
    capPin = 1'b0; step(l);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog: got %0d expected below 100000", cycles);
        summary();
      end
    end
  end

  initial begin
    logic [31:0] v, c0, c1, a1, a2;
    step(3);
    rstN = 1'b1;
    step(1);

    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      rd(3'(i), v);
      chk("R1", v, 32'h0);
    end

    // R2 counting and holding
    wr(3'd0, RUN);
    rd(3'd1, c0); step(10); rd(3'd1, c1);
    chk("R2 run", c1 - c0, 32'd10);
    wr(3'd0, 32'h0);
    rd(3'd1, c0); step(5); rd(3'd1, c1);
    chk("R2 hold", c1, c0);

    // R3 count write wins and continues
    wr(3'd0, RUN);
    wr(3'd1, 32'h1234);
    rd(3'd1, v); chk("R3 write", v, 32'h1234);
    step(1); rd(3'd1, v); chk("R3 continue", v, 32'h1235);

    // R4 overflow without and with reload
    wr(3'd1, 32'hFFFF_FFFE);
    step(1); rd(3'd1, v); chk("R4 max", v, 32'hFFFF_FFFF);
    step(1); rd(3'd1, v); chk("R4 wrap", v, 32'h0);
    wr(3'd2, 32'h100);
    wr(3'd0, RUN | ARL);
    wr(3'd1, 32'hFFFF_FFFE);
    step(2); rd(3'd1, v); chk("R4 reload", v, 32'h100);

    // Table: R8 period and high time
    foreach (VEC[k]) begin
      wr(3'd0, 32'h0);
      capPin = 1'b0; step(4);
      wr(3'd5, 32'h3);
      wr(3'd1, 32'h0);
      wr(3'd0, RUN | PAIR | PIN | {22'd0, VEC[k][25:24], 8'd0});
      pulse(int'(VEC[k][23:16]), int'(VEC[k][15:8]));
      pulse(int'(VEC[k][23:16]), int'(VEC[k][15:8]));
      step(4);
      rd(3'd3, a1); rd(3'd4, a2);
      chk("R8 interval", a2 - a1, {24'd0, VEC[k][7:0]});
      rd(3'd5, v); chk("R10 both flags", v, 32'h3);
    end

    // R8 across counter wrap
    wr(3'd0, 32'h0);
    wr(3'd5, 32'h3);
    wr(3'd1, 32'hFFFF_FFF8);
    wr(3'd0, RUN | PAIR | PIN | 32'h100);
    pulse(10, 10); pulse(10, 10); step(4);
    rd(3'd3, a1); rd(3'd4, a2);
    chk("R8 wrap diff", a2 - a1, 32'd20);
    chk("R8 wrap crossed", {31'd0, a2 < a1}, 32'd1);

    // R6 and R9 paired sequence, latency, ignore third, rearm
    wr(3'd5, 32'h3);
    wr(3'd0, RUN | PAIR | PIN | 32'h100);
    step(2);
    rd(3'd1, c0);
    capPin = 1'b1; step(4); capPin = 1'b0; step(4);
    rd(3'd3, v); chk("R9 latency", v, c0 + 32'd2);
    rd(3'd1, c1);
    capPin = 1'b1; step(4); capPin = 1'b0; step(4);
    rd(3'd4, a2); chk("R6 second", a2, c1 + 32'd2);
    rd(3'd3, a1);
    pulse(4, 4); step(2);
    rd(3'd4, v); chk("R6 third ignored cap2", v, a2);
    rd(3'd3, v); chk("R6 third ignored cap1", v, a1);
    wr(3'd0, RUN | PAIR | PIN | 32'h100);
    rd(3'd1, c0);
    capPin = 1'b1; step(4); capPin = 1'b0; step(4);
    rd(3'd3, v); chk("R6 rearm cap1", v, c0 + 32'd2);
    rd(3'd4, v); chk("R6 rearm cap2 kept", v, a2);

    // R5 capture gating
    wr(3'd5, 32'h3);
    rd(3'd3, a1);
    wr(3'd0, RUN | PIN);
    pulse(4, 4); step(2);
    rd(3'd5, v); chk("R5 sel 00", v, 32'h0);
    wr(3'd0, RUN | 32'h100);
    pulse(4, 4); step(2);
    rd(3'd5, v); chk("R5 pin not selected", v, 32'h0);
    wr(3'd0, PIN | 32'h100);
    pulse(4, 4); step(2);
    rd(3'd5, v); chk("R5 stopped", v, 32'h0);
    rd(3'd3, v); chk("R5 cap1 unchanged", v, a1);

    // R7 single mode: every event to cap1, cap2 untouched
    rd(3'd4, a2);
    wr(3'd0, RUN | PIN | 32'h100);
    pulse(3, 5);
    rd(3'd1, c0);
    capPin = 1'b1; step(4); capPin = 1'b0; step(4);
    rd(3'd3, v); chk("R7 latest in cap1", v, c0 + 32'd2);
    rd(3'd4, v); chk("R7 cap2 untouched", v, a2);
    rd(3'd5, v); chk("R7 status", v, 32'h1);

    // R10 write-one-to-clear
    wr(3'd5, 32'h0);
    rd(3'd5, v); chk("R10 write zero", v, 32'h1);
    wr(3'd5, 32'h2);
    rd(3'd5, v); chk("R10 other bit", v, 32'h1);
    wr(3'd5, 32'h1);
    rd(3'd5, v); chk("R10 clear", v, 32'h0);

    // R11 clear low control bits but keep run
    wr(3'd0, RUN | PAIR | PIN | 32'h300);
    wr(3'd0, RUN);
    rd(3'd0, v); chk("R11 control", v, RUN);
    rd(3'd1, c0); pulse(4, 4); step(2); rd(3'd1, c1);
    chk("R11 running", c1 - c0, 32'd10);
    rd(3'd5, v); chk("R11 no capture", v, 32'h0);

    summary();
  end
endmodule